// File: doc/BRIEF.md
# Add-Only Memory Byte Program-and-Verify Sequencer

This block runs the byte-write dialogue of a one-wire add-only memory, one byte at a time. The line-side decoder hands it received bytes: a write command, the low and high bytes of a start address, then one data byte. The block answers the next read with a CRC-8 taken over those four bytes. The address bytes enter that CRC after masking, so an address outside the target field gives a CRC that differs from the master's own. The master then sends a programming pulse, and the block raises a single-cycle program strobe to the memory array.

Programming can only clear bits. The strobe therefore carries the new data ANDed with the byte already stored. After the strobe, the next read returns the byte now held at that address, so the master can confirm every zero landed. Any later read returns all ones until the line is reset.

Two targets share the same dialogue. One command code selects the 128-byte data array. A second code selects the 8-byte status field. A per-page protect input, active low, blocks the strobe for data-array pages that have been locked. A line reset abandons the sequence at any point.

Top module: `eprom_wr_seq`

## Requirements
- R1: The first received byte after reset or line reset is the command. 0x0F selects the data array (arr_sel=0) and 0x55 selects the status field (arr_sel=1). Any other code puts the block in a state where every read returns 0xFF and no program strobe is raised until the next line reset.
- R2: The first read after the data byte returns a CRC-8 over command, masked TA1, masked TA2 and data, in that order. The CRC uses polynomial x^8+x^5+x^4+1, starts from 0x00 and shifts each byte in LSB first.
- R3: Address bits above bit 6 (data array) or above bit 2 (status field) are cleared before they enter the CRC and before they are used as arr_addr.
- R4: A program pulse that arrives before the CRC byte has been read raises no strobe and changes no state.
- R5: A program pulse after the CRC read raises arr_we for exactly one cycle, starting the cycle after the pulse is sampled. During that cycle arr_addr holds the masked address, arr_sel holds the target, and arr_wdata holds the data byte ANDed with arr_rdata.
- R6: The first read after the strobe returns arr_rdata at the programmed address, which is the AND of every byte written there.
- R7: For a data-array write to page p (address bits 6:5), wp_n[p]=0 suppresses the strobe. The verify byte then shows the unchanged contents. Status writes are not affected by wp_n.
- R8: Reads issued before the CRC is due, between the CRC and the strobe, or after the verify byte all return 0xFF.
- R9: line_rst returns the block to waiting for a command. A pulse after it raises no strobe, and the next read returns 0xFF.
- R10: Each tx_req sampled on a clock edge makes tx_valid high for exactly the following cycle, with tx_byte valid during that cycle.
- R11: After rst_n, tx_valid and arr_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_rst | input | 1 | Reset pulse seen on the line; abandons the sequence |
| rx_valid | input | 1 | A byte from the master is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Master wants the next byte |
| tx_valid | output | 1 | tx_byte holds the answer to the last tx_req |
| tx_byte | output | 8 | Byte returned to the master |
| prog_pulse | input | 1 | Programming pulse detected on the line |
| wp_n | input | 4 | Per-page write enable of the data array, 0 = locked |
| arr_we | output | 1 | Single-cycle program strobe |
| arr_sel | output | 1 | Target of the strobe and read port: 0 data array, 1 status field |
| arr_addr | output | 7 | Masked byte address for program and read |
| arr_wdata | output | 8 | Byte to store (new data AND old contents) |
| arr_rdata | input | 8 | Stored byte at arr_sel/arr_addr |

## Verification
The dialogue is tried with an in-range address on a fresh byte, and then again on the same byte with overlapping zeros. That pair separates a plain overwrite from the AND result on read-back. An address with high bits set is used for both targets, which shows whether masking reaches the CRC as well as the strobe address. Other runs send a program pulse early, issue a read before the CRC is due, lock a page, reset the line mid-sequence, and send an unknown command. Together these separate correct gating from a strobe raised on any pulse, and a frozen dialogue from one that answers 0xFF.

// File: rtl/eprom_wr_pkg.sv
package eprom_wr_pkg;

  typedef enum logic [3:0] {
    ST_CMD,   // waiting for the command byte
    ST_TA1,   // waiting for address low byte
    ST_TA2,   // waiting for address high byte
    ST_DAT,   // waiting for the data byte
    ST_CRC,   // CRC byte due on the next read
    ST_ARM,   // waiting for the programming pulse
    ST_PROG,  // strobe cycle
    ST_VFY,   // verify byte due on the next read
    ST_TAIL   // all-ones until line reset
  } seq_state_t;

  localparam logic [7:0] CRC8_POLY_REFL = 8'h8C;
  localparam logic [7:0] IDLE_FILL      = 8'hFF;

  // one byte through the reflected CRC-8, LSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] b);
    logic [7:0] c;
    c = acc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC8_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/ewr_crc8.sv
module ewr_crc8
  import eprom_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  logic [7:0] crc_q;
  logic [7:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (en) crc_d = crc8_step(restart ? 8'h00 : crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 8'h00;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/ewr_capture.sv
module ewr_capture #(
  parameter int          AW       = 7,
  parameter int          SAW      = 3,
  parameter logic [7:0]  CMD_STAT = 8'h55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_cmd,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          ld_dat,
  input  logic [7:0]    din,
  output logic          is_stat,
  output logic [AW-1:0] addr,
  output logic [7:0]    dat,
  output logic [7:0]    crc_in
);

  // AW is at most 16: the address travels in two bytes
  localparam logic [15:0] MAIN_MASK = 16'((32'd1 << AW) - 32'd1);
  localparam logic [15:0] STAT_MASK = 16'((32'd1 << SAW) - 32'd1);

  logic          stat_q, stat_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    dat_q,  dat_d;
  logic [15:0]   mask;
  logic [15:0]   wide;

  assign mask = stat_q ? STAT_MASK : MAIN_MASK;

  always_comb begin
    wide = 16'(addr_q);
    if (ld_lo) wide[7:0]  = din;
    if (ld_hi) wide[15:8] = din;
    wide = wide & mask;
    if (ld_lo)      crc_in = wide[7:0];
    else if (ld_hi) crc_in = wide[15:8];
    else            crc_in = din;
  end

  always_comb begin
    stat_d = stat_q;
    addr_d = addr_q;
    dat_d  = dat_q;
    if (ld_cmd) begin
      stat_d = (din == CMD_STAT);
      addr_d = '0;
    end
    if (ld_lo || ld_hi) addr_d = wide[AW-1:0];
    if (ld_dat)         dat_d  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      addr_q <= '0;
      dat_q  <= 8'h00;
    end else begin
      stat_q <= stat_d;
      addr_q <= addr_d;
      dat_q  <= dat_d;
    end
  end

  assign is_stat = stat_q;
  assign addr    = addr_q;
  assign dat     = dat_q;

  // status-field address never leaves its field
  assert_stat_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q |-> (int'(addr_q) < (1 << SAW)));

endmodule

// File: rtl/eprom_wr_seq.sv
module eprom_wr_seq
  import eprom_wr_pkg::*;
#(
  parameter int         AW       = 7,
  parameter int         SAW      = 3,
  parameter int         PAGE_AW  = 5,
  parameter logic [7:0] CMD_MAIN = 8'h0F,
  parameter logic [7:0] CMD_STAT = 8'h55,
  localparam int        NPAGE    = 1 << (AW - PAGE_AW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             tx_req,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic             prog_pulse,
  input  logic [NPAGE-1:0] wp_n,
  output logic             arr_we,
  output logic             arr_sel,
  output logic [AW-1:0]    arr_addr,
  output logic [7:0]       arr_wdata,
  input  logic [7:0]       arr_rdata
);

  localparam int PW = AW - PAGE_AW;

  seq_state_t st_q, st_d;
  logic       txv_q, txv_d;
  logic [7:0] txb_q, txb_d;
  logic       we_q,  we_d;
  logic [7:0] wd_q,  wd_d;

  logic ld_cmd, ld_lo, ld_hi, ld_dat;
  logic crc_en, crc_restart;
  logic [7:0] crc_in, crc_val, dat_q;
  logic is_stat;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] page;
  logic [NPAGE-1:0] page_lock;
  logic blocked;

  ewr_capture #(.AW(AW), .SAW(SAW), .CMD_STAT(CMD_STAT)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .ld_cmd(ld_cmd), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_dat(ld_dat),
    .din(rx_byte), .is_stat(is_stat), .addr(addr_q), .dat(dat_q), .crc_in(crc_in)
  );

  ewr_crc8 u_crc (
    .clk(clk), .rst_n(rst_n), .en(crc_en), .restart(crc_restart),
    .din(crc_in), .crc(crc_val)
  );

  // per-page lock decode of the data array
  assign page = addr_q[AW-1:PAGE_AW];
  for (genvar p = 0; p < NPAGE; p++) begin : g_lock
    assign page_lock[p] = (int'(page) == p) && !wp_n[p];
  end
  assign blocked = !is_stat && (|page_lock);

  always_comb begin
    st_d        = st_q;
    txv_d       = 1'b0;
    txb_d       = txb_q;
    we_d        = 1'b0;
    wd_d        = wd_q;
    ld_cmd      = 1'b0;
    ld_lo       = 1'b0;
    ld_hi       = 1'b0;
    ld_dat      = 1'b0;
    crc_en      = 1'b0;
    crc_restart = 1'b0;
    if (line_rst) begin
      st_d = ST_CMD;
    end else begin
      if (tx_req) begin
        txv_d = 1'b1;
        txb_d = IDLE_FILL;
        case (st_q)
          ST_CRC: begin txb_d = crc_val;   st_d = ST_ARM;  end
          ST_VFY: begin txb_d = arr_rdata; st_d = ST_TAIL; end
          default: ;
        endcase
      end else if (rx_valid) begin
        case (st_q)
          ST_CMD: begin
            if (rx_byte == CMD_MAIN || rx_byte == CMD_STAT) begin
              ld_cmd = 1'b1; crc_en = 1'b1; crc_restart = 1'b1; st_d = ST_TA1;
            end else begin
              st_d = ST_TAIL;
            end
          end
          ST_TA1: begin ld_lo  = 1'b1; crc_en = 1'b1; st_d = ST_TA2; end
          ST_TA2: begin ld_hi  = 1'b1; crc_en = 1'b1; st_d = ST_DAT; end
          ST_DAT: begin ld_dat = 1'b1; crc_en = 1'b1; st_d = ST_CRC; end
          default: ;
        endcase
      end else if (prog_pulse && st_q == ST_ARM) begin
        st_d = ST_PROG;
        we_d = !blocked;
        wd_d = dat_q & arr_rdata;
      end
      if (st_q == ST_PROG) st_d = ST_VFY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_CMD;
      txv_q <= 1'b0;
      txb_q <= 8'h00;
      we_q  <= 1'b0;
      wd_q  <= 8'h00;
    end else begin
      st_q  <= st_d;
      txv_q <= txv_d;
      txb_q <= txb_d;
      we_q  <= we_d;
      wd_q  <= wd_d;
    end
  end

  assign tx_valid  = txv_q;
  assign tx_byte   = txb_q;
  assign arr_we    = we_q;
  assign arr_wdata = wd_q;
  assign arr_sel   = is_stat;
  assign arr_addr  = addr_q;

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);

  assert_strobe_needs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> ($past(prog_pulse) && !$past(line_rst)));

  assert_tx_answers_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req));

  assert_add_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> ((arr_wdata & ~arr_rdata) == 8'h00));

  assert_locked_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !arr_sel) |-> wp_n[arr_addr[AW-1:PAGE_AW]]);

  assert_line_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_rst |=> (!tx_valid && !arr_we));

endmodule

// File: tb/eprom_wr_seq_test.sv
`timescale 1ns/1ps
module eprom_wr_seq_test;
  localparam int AW = 7, SAW = 3, PAGE_AW = 5, NPAGE = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, line_rst, rx_valid, tx_req, prog_pulse;
  logic [7:0] rx_byte;
  logic [NPAGE-1:0] wp_n;
  logic tx_valid, arr_we, arr_sel;
  logic [7:0] tx_byte, arr_wdata, arr_rdata;
  logic [AW-1:0] arr_addr;

  eprom_wr_seq uut (
    .clk(clk), .rst_n(rst_n), .line_rst(line_rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte), .prog_pulse(prog_pulse),
    .wp_n(wp_n), .arr_we(arr_we), .arr_sel(arr_sel), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // behavioural array: bits only ever go from 1 to 0
  logic [7:0] mmem [0:(1<<AW)-1];
  logic [7:0] smem [0:(1<<SAW)-1];
  assign arr_rdata = arr_sel ? smem[arr_addr[SAW-1:0]] : mmem[arr_addr];
  always @(posedge clk)
    if (arr_we) begin
      if (arr_sel) smem[arr_addr[SAW-1:0]] <= smem[arr_addr[SAW-1:0]] & arr_wdata;
      else         mmem[arr_addr]          <= mmem[arr_addr] & arr_wdata;
    end

  int nvec = 0, nbad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] crc_q8(input logic [7:0] q[$]);
    logic [7:0] c = 8'h00;
    foreach (q[k]) for (int i = 0; i < 8; i++) begin
      logic fb = c[0] ^ q[k][i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [15:0] fmask(input bit st);
    return st ? 16'((1 << SAW) - 1) : 16'((1 << AW) - 1);
  endfunction

  // cycle-by-cycle reference model
  int ph, prev;
  logic [7:0] q[$];
  bit m_stat;
  logic [15:0] m_addr;
  logic [7:0] m_dat, cur;
  logic e_v, e_we, e_ws;
  logic [7:0] e_b, e_wd;
  logic [AW-1:0] e_wa;
  string e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; e_v = 0; e_we = 0;
    end else begin
      prev = ph; e_v = 0; e_we = 0;
      if (line_rst) ph = 0;
      else begin
        if (tx_req) begin
          e_v = 1; e_b = 8'hFF; e_tag = "R8";
          if (ph == 4) begin e_b = crc_q8(q); e_tag = "R2"; ph = 5; end
          else if (ph == 7) begin
            e_b = m_stat ? smem[m_addr[SAW-1:0]] : mmem[m_addr[AW-1:0]];
            e_tag = "R6"; ph = 8;
          end
        end else if (rx_valid) begin
          case (ph)
            0: if (rx_byte == 8'h0F || rx_byte == 8'h55) begin
                 q = {rx_byte}; m_stat = (rx_byte == 8'h55); m_addr = 0; ph = 1;
               end else ph = 8;
            1: begin m_addr[7:0]  = rx_byte & fmask(m_stat)[7:0];  q.push_back(m_addr[7:0]);  ph = 2; end
            2: begin m_addr[15:8] = rx_byte & fmask(m_stat)[15:8]; q.push_back(m_addr[15:8]); ph = 3; end
            3: begin m_dat = rx_byte; q.push_back(rx_byte); ph = 4; end
            default: ;
          endcase
        end else if (prog_pulse && ph == 5) begin
          ph = 6;
          cur = m_stat ? smem[m_addr[SAW-1:0]] : mmem[m_addr[AW-1:0]];
          e_we = m_stat || wp_n[m_addr[AW-1:PAGE_AW]];
          e_wd = m_dat & cur; e_wa = m_addr[AW-1:0]; e_ws = m_stat;
        end
        if (prev == 6) ph = 7;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check(tx_valid === e_v, "R10 tx_valid", tx_valid, e_v);
    if (e_v) check(tx_byte === e_b, e_tag, tx_byte, e_b);
    check(arr_we === e_we, "R5 arr_we", arr_we, e_we);
    if (e_we) check({arr_sel, arr_addr, arr_wdata} === {e_ws, e_wa, e_wd}, "R5 strobe fields",
                    {arr_sel, arr_addr, arr_wdata}, {e_ws, e_wa, e_wd});
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk) rx_valid = 1; rx_byte = b;
    @(negedge clk) rx_valid = 0;
  endtask
  task automatic rd(output logic [7:0] b);
    @(negedge clk) tx_req = 1;
    @(negedge clk) tx_req = 0; b = tx_byte;
  endtask
  task automatic pulse();
    @(negedge clk) prog_pulse = 1;
    @(negedge clk) prog_pulse = 0;
  endtask
  task automatic lreset();
    @(negedge clk) line_rst = 1;
    @(negedge clk) line_rst = 0;
  endtask
  task automatic head(input logic [7:0] c, input logic [15:0] a, input logic [7:0] d);
    send(c); send(a[7:0]); send(a[15:8]); send(d);
  endtask
  function automatic logic [7:0] crc4(input logic [7:0] c, input logic [15:0] a, input logic [7:0] d);
    logic [15:0] m = a & fmask(c == 8'h55);
    return crc_q8({c, m[7:0], m[15:8], d});
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  logic [7:0] b;
  initial begin
    foreach (mmem[i]) mmem[i] = 8'hFF;
    foreach (smem[i]) smem[i] = 8'hFF;
    rst_n = 0; line_rst = 0; rx_valid = 0; tx_req = 0; prog_pulse = 0; rx_byte = 0; wp_n = '1;
    repeat (4) @(negedge clk);
    check(tx_valid === 1'b0 && arr_we === 1'b0, "R11 reset outputs", {tx_valid, arr_we}, 0);
    rst_n = 1;

    // fresh byte
    head(8'h0F, 16'h0012, 8'hA5);
    rd(b); check(b === crc4(8'h0F, 16'h0012, 8'hA5), "R2 crc", b, crc4(8'h0F, 16'h0012, 8'hA5));
    pulse();
    rd(b); check(b === 8'hA5, "R6 verify fresh", b, 8'hA5);
    check(mmem[8'h12] === 8'hA5, "R5 array written", mmem[8'h12], 8'hA5);
    rd(b); check(b === 8'hFF, "R8 tail", b, 8'hFF);
    lreset();

    // same byte again: AND result
    head(8'h0F, 16'h0012, 8'h3C);
    rd(b); check(b === crc4(8'h0F, 16'h0012, 8'h3C), "R2 crc second", b, crc4(8'h0F, 16'h0012, 8'h3C));
    pulse();
    rd(b); check(b === 8'h24, "R6 verify AND", b, 8'h24);
    lreset();

    // out-of-range address
    head(8'h0F, 16'h1234, 8'h77);
    rd(b); check(b === crc4(8'h0F, 16'h0034, 8'h77), "R3 masked crc", b, crc4(8'h0F, 16'h0034, 8'h77));
    check(b !== crc_q8({8'h0F, 8'h34, 8'h12, 8'h77}), "R3 crc differs from unmasked", b, 0);
    pulse();
    rd(b); check(mmem[8'h34] === 8'h77 && b === 8'h77, "R3 masked target", mmem[8'h34], 8'h77);
    lreset();

    // early pulse ignored
    head(8'h0F, 16'h0050, 8'h0F);
    pulse();
    check(mmem[8'h50] === 8'hFF, "R4 early pulse no write", mmem[8'h50], 8'hFF);
    rd(b); check(b === crc4(8'h0F, 16'h0050, 8'h0F), "R4 crc after early pulse", b, crc4(8'h0F, 16'h0050, 8'h0F));
    rd(b); check(b === 8'hFF, "R8 read while armed", b, 8'hFF);
    pulse();
    rd(b); check(b === 8'h0F, "R4 real pulse programs", b, 8'h0F);
    lreset();

    // locked page
    wp_n = 4'b1011;
    head(8'h0F, 16'h0045, 8'h00);
    rd(b); pulse();
    rd(b); check(b === 8'hFF, "R7 locked verify", b, 8'hFF);
    check(mmem[8'h45] === 8'hFF, "R7 locked array", mmem[8'h45], 8'hFF);
    lreset();

    // status field, address beyond field, locks ignored
    head(8'h55, 16'h000B, 8'hF0);
    rd(b); check(b === crc4(8'h55, 16'h000B, 8'hF0), "R3 status crc", b, crc4(8'h55, 16'h000B, 8'hF0));
    pulse();
    rd(b); check(b === 8'hF0, "R1 status verify", b, 8'hF0);
    check(smem[3] === 8'hF0 && mmem[3] === 8'hFF, "R1 status target", smem[3], 8'hF0);
    lreset();
    wp_n = '1;

    // line reset mid-sequence
    head(8'h0F, 16'h0020, 8'h00);
    rd(b); lreset(); pulse();
    check(mmem[8'h20] === 8'hFF, "R9 abandoned no write", mmem[8'h20], 8'hFF);
    rd(b); check(b === 8'hFF, "R9 read after line reset", b, 8'hFF);
    head(8'h0F, 16'h0020, 8'hC3);
    rd(b); pulse();
    rd(b); check(b === 8'hC3, "R9 restart works", b, 8'hC3);
    lreset();

    // unknown command
    head(8'hCC, 16'h0020, 8'h00);
    rd(b); check(b === 8'hFF, "R1 unknown command read", b, 8'hFF);
    pulse();
    check(mmem[8'h20] === 8'hC3, "R1 unknown command no write", mmem[8'h20], 8'hC3);
    lreset();

    // read before CRC is due
    send(8'h0F);
    rd(b); check(b === 8'hFF, "R8 early read", b, 8'hFF);
    send(8'h21); send(8'h00); send(8'h81);
    rd(b); check(b === crc4(8'h0F, 16'h0021, 8'h81), "R2 crc after early read", b, crc4(8'h0F, 16'h0021, 8'h81));
    pulse();
    rd(b); check(b === 8'h81, "R6 verify after early read", b, 8'h81);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule